// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Emulator

This block is a synthesizable behavioural model of the write front end of a byte-wide parallel nonvolatile memory. A host drives an asynchronous-style bus made of active-low chip enable, write enable and output enable, an address and a byte of data. The block samples that bus on a system clock. The array is made of on-chip registers and is erased to all ones at reset. By default it holds 32 pages of 64 bytes. Setting `ROW_W` to 7 gives the 8K x 8 organisation.

A host writes a page as a burst of byte loads. The first load fixes the page row. Each later load to the same row goes into a page buffer and restarts a load window. When the window expires without a new load, a timed program cycle runs, and at its end every buffered byte is committed to the array in one step. While the block is busy, a read returns polling status instead of array data. Bit 7 holds the complement of bit 7 of the last loaded byte, and bit 6 alternates on every new read. A host can therefore detect completion either by data polling or by toggle-bit polling. A separate protection block can assert `write_inhibit_i` to stop the commit.

The default `PROG_CYCLES` assumes a 100 MHz clock and splits a 0.25 s full-array write budget evenly over 128 pages.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset the block is idle, `data_oe_o` is low with no read strobe, and every array byte reads back as 8'hFF.
- R2: A byte load is taken when the write strobe ends, that is, when the first of CE and WE rises while the other is low. It is taken only if OE was high during the strobe. A strobe with OE low changes nothing.
- R3: The row bits (address bits above the low `COL_W` bits) of the first load select the page. Loads to any other row during the load window are ignored.
- R4: A page takes 1 to `PAGE_BYTES` loads. If a column is loaded twice, the last value is kept. After the commit, every loaded byte of the page holds its value and unloaded bytes are unchanged.
- R5: Each accepted load restarts a window of `WINDOW_CYCLES` clocks. Programming starts when the window expires with no new load.
- R6: Programming lasts `PROG_CYCLES` clocks. Completion becomes visible about `WINDOW_CYCLES + PROG_CYCLES` clocks after the last load, within a few clocks of sampling latency.
- R7: While busy (load window or program cycle), a read at any address returns bit 7 equal to the complement of bit 7 of the last loaded byte, with bits 5..0 zero. Once idle, a read returns array data.
- R8: While busy, bit 6 of successive reads alternates. Once idle, repeated reads of one address return identical data.
- R9: Pulsing OE low with CE high between loads does not drive the bus and does not disturb the page being loaded.
- R10: Write strobes during the program cycle are ignored. This holds both for the page's own row and for other rows.
- R11: If `write_inhibit_i` is high when the program cycle ends, the array is left unchanged. The busy period still runs to completion.
- R12: `data_oe_o` is high exactly while CE is low, OE is low and WE is high, delayed by one sampling register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address (row bits above column bits) |
| data_i | input | DATA_W | Write data |
| write_inhibit_i | input | 1 | Blocks the array commit when high |
| data_o | output | DATA_W | Read data or polling status |
| data_oe_o | output | 1 | Read data is being driven |

## Verification
The assertions assume a single bus master that never requests a read and a write in the same strobe. They also assume address and data stay stable for the strobe and for one clock after it ends, and that `write_inhibit_i` changes only while the block is idle. The bench drives every input on the falling clock edge. It holds address and data through each strobe and for one clock after it, keeps every gap between loads well inside the load window, and sets or clears the inhibit input only before a page starts. Under those conditions, the checks cover four properties of the internal state: state order, the ban on buffer writes while programming, the empty buffer while idle, and the stable status bit while programming.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eep_state_e;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_done_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_act_o,
  output logic              rd_start_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic              ce_s, we_s, oe_s;
  logic [ADDR_W-1:0] addr_s, addr_d;
  logic [DATA_W-1:0] data_s, data_d;
  logic              wr_act_s, wr_act_d, oe_d, rd_act_d;

  assign wr_act_s = ~ce_s & ~we_s;
  assign rd_act_o = ~ce_s & ~oe_s & we_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_s     <= 1'b1;
      we_s     <= 1'b1;
      oe_s     <= 1'b1;
      addr_s   <= '0;
      data_s   <= '0;
      wr_act_d <= 1'b0;
      oe_d     <= 1'b1;
      rd_act_d <= 1'b0;
      addr_d   <= '0;
      data_d   <= '0;
    end else begin
      ce_s     <= ce_ni;
      we_s     <= we_ni;
      oe_s     <= oe_ni;
      addr_s   <= addr_i;
      data_s   <= data_i;
      wr_act_d <= wr_act_s;
      oe_d     <= oe_s;
      rd_act_d <= rd_act_o;
      addr_d   <= addr_s;
      data_d   <= data_s;
    end
  end

  // strobe end: first of CE/WE to rise; OE must have been high in the last active cycle
  assign wr_done_o  = wr_act_d & ~wr_act_s & oe_d;
  assign wr_addr_o  = addr_d;
  assign wr_data_o  = data_d;
  assign rd_start_o = rd_act_o & ~rd_act_d;
  assign rd_addr_o  = addr_s;
endmodule

// File: rtl/eep_prog_ctrl.sv
module eep_prog_ctrl
  import eep_pkg::*;
#(
  parameter int WINDOW_CYCLES = 10000,
  parameter int PROG_CYCLES   = 195312
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_done_i,
  input  logic       row_hit_i,
  input  logic       rd_start_i,
  output eep_state_e state_o,
  output logic       buf_we_o,
  output logic       first_o,
  output logic       commit_o,
  output logic       busy_o,
  output logic       toggle_o
);
  localparam int MAX_CNT = (WINDOW_CYCLES > PROG_CYCLES) ? WINDOW_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WINDOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);

  eep_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tog_q;
  logic             accept;

  assign accept   = wr_done_i &
                    ((state_q == ST_IDLE) || ((state_q == ST_LOAD) && row_hit_i));
  assign buf_we_o = accept;
  assign first_o  = accept & (state_q == ST_IDLE);
  assign commit_o = (state_q == ST_PROG) && (cnt_q == PROG_LAST);
  assign busy_o   = (state_q != ST_IDLE);
  assign state_o  = state_q;
  assign toggle_o = tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tog_q   <= 1'b0;
    end else begin
      if (rd_start_i && busy_o) tog_q <= ~tog_q;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
          end
        end
        ST_LOAD: begin
          if (accept) begin
            cnt_q <= '0;
          end else if (cnt_q == WIN_LAST) begin
            state_q <= ST_PROG;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (cnt_q == PROG_LAST) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int ROW_W  = 5,
  parameter int COL_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  first_i,
  input  logic                  clr_i,
  input  logic [ROW_W-1:0]      row_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic [ROW_W-1:0]      row_o,
  output logic [(1<<COL_W)-1:0] valid_o,
  output logic [DATA_W-1:0]     bytes_o [1<<COL_W],
  output logic                  last_msb_o
);
  localparam int PAGE_BYTES = 1 << COL_W;

  logic [PAGE_BYTES-1:0] valid_q;
  logic [ROW_W-1:0]      row_q;
  logic                  last_msb_q;
  logic [DATA_W-1:0]     mem_q [PAGE_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      row_q      <= '0;
      last_msb_q <= 1'b0;
    end else if (clr_i) begin
      valid_q <= '0;
    end else if (we_i) begin
      if (first_i) begin
        row_q   <= row_i;
        valid_q <= PAGE_BYTES'(1) << col_i;
      end else begin
        valid_q[col_i] <= 1'b1;
      end
      last_msb_q <= data_i[DATA_W-1];
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[col_i] <= data_i;
  end

  assign row_o      = row_q;
  assign valid_o    = valid_q;
  assign bytes_o    = mem_q;
  assign last_msb_o = last_msb_q;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ROW_W  = 5,
  parameter int COL_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    commit_i,
  input  logic [ROW_W-1:0]        row_i,
  input  logic [(1<<COL_W)-1:0]   valid_i,
  input  logic [DATA_W-1:0]       bytes_i [1<<COL_W],
  input  logic [ROW_W+COL_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]       rd_data_o
);
  localparam int PAGE_BYTES = 1 << COL_W;
  localparam int DEPTH      = 1 << (ROW_W + COL_W);

  logic [DATA_W-1:0] cell_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) cell_q[a] <= '1;
    end else if (commit_i) begin
      for (int c = 0; c < PAGE_BYTES; c++) begin
        if (valid_i[c]) cell_q[{row_i, COL_W'(c)}] <= bytes_i[c];
      end
    end
  end

  assign rd_data_o = cell_q[rd_addr_i];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eep_pkg::*;
#(
  parameter int ROW_W         = 5,
  parameter int COL_W         = 6,
  parameter int DATA_W        = 8,
  parameter int WINDOW_CYCLES = 10000,
  parameter int PROG_CYCLES   = 195312,
  localparam int ADDR_W       = ROW_W + COL_W,
  localparam int PAGE_BYTES   = 1 << COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              write_inhibit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic              wr_done, rd_act, rd_start;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, arr_data;
  eep_state_e        state;
  logic              buf_we, first, commit, busy, toggle, last_msb, row_hit;
  logic [ROW_W-1:0]      buf_row;
  logic [PAGE_BYTES-1:0] buf_valid;
  logic [DATA_W-1:0]     buf_bytes [PAGE_BYTES];
  logic [DATA_W-1:0]     status;

  eep_bus_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .addr_i(addr_i), .data_i(data_i),
    .wr_done_o(wr_done), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_act_o(rd_act), .rd_start_o(rd_start), .rd_addr_o(rd_addr)
  );

  assign row_hit = (wr_addr[ADDR_W-1:COL_W] == buf_row);

  eep_prog_ctrl #(.WINDOW_CYCLES(WINDOW_CYCLES), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_done_i(wr_done), .row_hit_i(row_hit), .rd_start_i(rd_start),
    .state_o(state), .buf_we_o(buf_we), .first_o(first),
    .commit_o(commit), .busy_o(busy), .toggle_o(toggle)
  );

  eep_page_buf #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(buf_we), .first_i(first), .clr_i(commit),
    .row_i(wr_addr[ADDR_W-1:COL_W]), .col_i(wr_addr[COL_W-1:0]), .data_i(wr_data),
    .row_o(buf_row), .valid_o(buf_valid), .bytes_o(buf_bytes), .last_msb_o(last_msb)
  );

  eep_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .commit_i(commit & ~write_inhibit_i),
    .row_i(buf_row), .valid_i(buf_valid), .bytes_i(buf_bytes),
    .rd_addr_i(rd_addr), .rd_data_o(arr_data)
  );

  always_comb begin
    status = '0;
    status[DATA_W-1] = ~last_msb;
    status[DATA_W-2] = toggle;
  end

  assign data_o    = busy ? status : arr_data;
  assign data_oe_o = rd_act;
endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk
  import eep_pkg::*;
#(
  parameter int PAGE_BYTES = 64
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input eep_state_e            state_i,
  input logic                  buf_we_i,
  input logic                  commit_i,
  input logic [PAGE_BYTES-1:0] valid_i,
  input logic                  last_msb_i
);
  assert_no_load_in_prog_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PROG) |-> !buf_we_i);

  assert_commit_only_in_prog_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (state_i == ST_PROG));

  assert_commit_then_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (state_i == ST_IDLE));

  assert_prog_after_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_PROG) && ($past(state_i) != ST_PROG)) |-> ($past(state_i) == ST_LOAD));

  assert_idle_buffer_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> (valid_i == '0));

  assert_status_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_PROG) && ($past(state_i) == ST_PROG)) |-> $stable(last_msb_i));
endmodule

bind eeprom_page_writer eep_page_writer_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state), .buf_we_i(buf_we),
  .commit_i(commit), .valid_i(buf_valid), .last_msb_i(last_msb)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
  localparam int ROW_W = 5;
  localparam int COL_W = 6;
  localparam int AW    = ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;
  localparam int WIN   = 40;
  localparam int PROG  = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic          inhibit = 1'b0;
  logic [7:0]    rdata;
  logic          rd_oe;
  logic [7:0]    ref_mem [DEPTH];
  int            n_vec = 0;
  int            n_bad = 0;

  always #5 clk = ~clk;

  eeprom_page_writer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(8),
    .WINDOW_CYCLES(WIN), .PROG_CYCLES(PROG)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(wdata), .write_inhibit_i(inhibit),
    .data_o(rdata), .data_oe_o(rd_oe)
  );

  function automatic logic [AW-1:0] mk(input int row, input int col);
    return {ROW_W'(row), COL_W'(col)};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [7:0] d, input logic oe_lvl);
    @(negedge clk);
    addr = a; wdata = d; oe_n = oe_lvl; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    d = rdata; oe = rd_oe;
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  // hold a read open and count clocks until the true byte appears
  task automatic poll_data(input logic [AW-1:0] a, input logic [7:0] exp, output int lat);
    lat = 0;
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    while (rdata !== exp && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic oe;
    chk("R12 idle data_oe low", {7'd0, rd_oe}, 8'd0);
    rd(mk(0, 0), d, oe);           chk("R1 erased byte row0", d, 8'hFF);
    chk("R12 data_oe during read", {7'd0, oe}, 8'd1);
    rd(mk(31, 63), d, oe);         chk("R1 erased byte top", d, 8'hFF);
  endtask

  task automatic t_two_byte;
    logic [7:0] d; logic oe; int lat;
    load(mk(3, 4), 8'h3C, 1'b1);     ref_mem[mk(3, 4)] = 8'h3C;
    load(mk(3, 5), 8'h77, 1'b0);     // R2: OE low, no load
    load(mk(3, 9), 8'hC1, 1'b1);     ref_mem[mk(3, 9)] = 8'hC1;
    rd(mk(0, 0), d, oe);
    chk("R7 status during window", d & 8'hBF, 8'h00);
    poll_data(mk(3, 9), 8'hC1, lat);
    n_vec++;
    if (lat < WIN + PROG - 6 || lat > WIN + PROG + 6) begin
      n_bad++;
      $display("FAIL R5/R6 completion latency: got %0d expected %0d", lat, WIN + PROG);
    end
    rd(mk(3, 4), d, oe);  chk("R4 two-byte page first", d, 8'h3C);
    rd(mk(3, 5), d, oe);  chk("R2 OE-low strobe ignored", d, 8'hFF);
    rd(mk(3, 9), d, oe);  chk("R4 two-byte page second", d, 8'hC1);
  endtask

  task automatic t_full_page;
    logic [7:0] d, prev; logic oe; int busy_rd; logic have_prev;
    for (int i = 0; i < 64; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 11);
      load(mk(5, i), v, 1'b1);
      ref_mem[mk(5, i)] = v;
      if (i == 10) begin
        @(negedge clk); oe_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 OE pulse with CE high not driven", {7'd0, rd_oe}, 8'd0);
        oe_n = 1'b1;
      end
      if (i == 20) begin
        rd(mk(1, 1), d, oe);
        chk("R7 status bit7 mid-page", d & 8'hBF, {~v[7], 7'd0});
      end
      if (i == 30) load(mk(6, 30), 8'h12, 1'b1);  // R3: other row ignored
    end
    load(mk(5, 0), 8'h5A, 1'b1);  ref_mem[mk(5, 0)] = 8'h5A;
    busy_rd = 0; have_prev = 1'b0;
    for (int k = 0; k < 200; k++) begin
      rd(mk(5, 0), d, oe);
      if (d === 8'h5A) break;
      busy_rd++;
      chk("R7 toggle-mode status bits", d & 8'hBF, 8'h80);
      if (have_prev) chk("R8 bit6 alternates", {7'd0, d[6]}, {7'd0, ~prev[6]});
      prev = d; have_prev = 1'b1;
    end
    chk("R8 saw busy reads", {7'd0, busy_rd > 1}, 8'd1);
    rd(mk(5, 0), d, oe);   chk("R8 stable after done", d, 8'h5A);
    rd(mk(5, 0), d, oe);   chk("R4 repeated column last wins", d, 8'h5A);
    rd(mk(5, 63), d, oe);  chk("R4 last column", d, ref_mem[mk(5, 63)]);
    rd(mk(6, 30), d, oe);  chk("R3 off-row load ignored", d, 8'hFF);
  endtask

  task automatic t_write_during_prog;
    logic [7:0] d; logic oe; int lat;
    load(mk(7, 0), 8'h11, 1'b1);  ref_mem[mk(7, 0)] = 8'h11;
    load(mk(7, 1), 8'h92, 1'b1);  ref_mem[mk(7, 1)] = 8'h92;
    repeat (WIN + 20) @(negedge clk);
    load(mk(7, 2), 8'h33, 1'b1);
    load(mk(8, 0), 8'h44, 1'b1);
    poll_data(mk(7, 1), 8'h92, lat);
    rd(mk(7, 1), d, oe);  chk("R4 page committed", d, 8'h92);
    rd(mk(7, 2), d, oe);  chk("R10 same-row write ignored", d, 8'hFF);
    rd(mk(8, 0), d, oe);  chk("R10 other-row write ignored", d, 8'hFF);
    repeat (WIN + 10) @(negedge clk);
    rd(mk(8, 0), d, oe);  chk("R10 no page started", d, 8'hFF);
  endtask

  task automatic t_inhibit;
    logic [7:0] d; logic oe; int lat;
    inhibit = 1'b1;
    load(mk(9, 0), 8'hA5, 1'b1);
    load(mk(9, 1), 8'h3C, 1'b1);
    rd(mk(9, 1), d, oe);  chk("R11 still busy", d & 8'hBF, 8'h80);
    poll_data(mk(9, 1), 8'hFF, lat);
    n_vec++;
    if (lat < WIN + PROG - 6) begin
      n_bad++;
      $display("FAIL R11 busy period shortened: got %0d expected %0d", lat, WIN + PROG);
    end
    rd(mk(9, 0), d, oe);  chk("R11 inhibited byte unchanged", d, 8'hFF);
    inhibit = 1'b0;
  endtask

  task automatic t_sweep;
    logic [7:0] d; logic oe;
    for (int a = 0; a < DEPTH; a++) begin
      rd(AW'(a), d, oe);
      chk("R4 array sweep", d, ref_mem[a]);
    end
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_two_byte();
    t_full_page();
    t_write_during_prog();
    t_inhibit();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule